// File: doc/BRIEF.md
# Pixel Array Readout Address Sequencer

This block steps through a two-dimensional image sensor array and produces the addressing and strobes that read it out. Only one row is ever driven, through one-hot row-select lines. For that row the block issues a reset strobe and then waits a programmable integration time. It then pulses a charge-transfer strobe while the row is still selected. Last, it walks a column address across the row toward the per-column converters, raising a data-valid flag on every column it visits.

Three scan patterns are available. The full scan visits every row and every column in ascending order. The subsampled scan visits every second or every third index in both dimensions, starting at zero. The region scan visits only a rectangle set by first and last row and column. All configuration is captured on the start strobe. A one-cycle frame-done pulse closes each frame, and an out-of-range rectangle is refused with a one-cycle error pulse. The array dimensions and the width of the integration counter are parameters.

Top module: `pix_scan_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `row_sel` is all zero and `pix_rst`, `xfer`, `pix_valid`, `frame_done` and `cfg_err` are all 0.
- R2: At most one `row_sel` line is high at any time. Exactly one is high from a row's reset strobe through its last data-valid cycle, and none is high while idle.
- R3: For each row the sequence is: `pix_rst` high for one cycle, then exactly `int_cycles` cycles with no strobe, then `xfer` high for one cycle, then data-valid cycles. The same row line is selected throughout.
- R4: With `mode` = 2'b00 (3 is treated the same), the frame visits all rows 0..ROWS-1 in ascending order. Within each row it visits columns 0..COLS-1 in ascending order, with `pix_valid` high for one cycle per pixel and `col_addr` giving the column.
- R5: With `mode` = 2'b01, row and column indices start at 0 and advance by 2 (`skip_three` = 0) or by 3 (`skip_three` = 1). They stop at the largest such index inside the array.
- R6: With `mode` = 2'b10, only rows `row_first`..`row_last` and columns `col_first`..`col_last` are visited, in ascending order. A single-pixel rectangle is allowed.
- R7: In mode 2'b10, if a first bound exceeds its last bound or a last bound lies outside the array, then in the cycle after the start strobe `cfg_err` is high for one cycle, and no row is selected and no pixel is read.
- R8: `frame_done` is high for exactly one cycle, in the cycle right after the last `pix_valid`. The block then stays idle, with no row selected, until the next start strobe.
- R9: Changes to `mode`, `skip_three`, the bounds or `int_cycles` after the start strobe have no effect on the frame in progress.
- R10: A start strobe during a frame is ignored, and the frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a frame when idle |
| mode | input | 2 | 00 full, 01 subsampled, 10 region, 11 full |
| skip_three | input | 1 | Subsampling step: 0 gives 2, 1 gives 3 |
| row_first | input | $clog2(ROWS) | First row of the region |
| row_last | input | $clog2(ROWS) | Last row of the region |
| col_first | input | $clog2(COLS) | First column of the region |
| col_last | input | $clog2(COLS) | Last column of the region |
| int_cycles | input | IW | Integration delay in cycles between reset and transfer |
| row_sel | output | ROWS | One-hot row-select lines |
| col_addr | output | $clog2(COLS) | Column being read, valid with `pix_valid` |
| pix_rst | output | 1 | Pixel reset strobe for the selected row |
| xfer | output | 1 | Charge-transfer strobe for the selected row |
| pix_valid | output | 1 | One pulse per pixel visited |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | One-cycle pulse on a refused region |

## Verification
The first reset strobe appears in the cycle after the start strobe is sampled, and `cfg_err` appears in that same cycle when the region is refused. `xfer` follows the reset strobe by `int_cycles` + 1 cycles, and the first data-valid follows `xfer` by one cycle. `frame_done` follows the last data-valid by one cycle. The bench drives inputs on falling edges and samples on falling edges. It stamps every strobe with a cycle count, so each of these distances is compared exactly, not merely as an ordering. The visited (row, column) pairs are logged and compared in full against a list built from the requirement for each pattern.

// File: rtl/pix_scan_pkg.sv
package pix_scan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_INTEG,
      ST_XFER,
      ST_READ,
      ST_DONE
   } scan_state_t;

   localparam logic [1:0] MODE_FULL   = 2'b00;
   localparam logic [1:0] MODE_SUB    = 2'b01;
   localparam logic [1:0] MODE_REGION = 2'b10;

endpackage

// File: rtl/pix_axis_plan.sv
module pix_axis_plan
   import pix_scan_pkg::*;
#(
   parameter int N  = 8,
   localparam int AW = $clog2(N)
) (
   input  logic [1:0]    mode,
   input  logic          skip_three,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic [AW-1:0] first,
   output logic [AW-1:0] last,
   output logic [1:0]    step,
   output logic          bad
);
   localparam int TOP   = N - 1;
   localparam int LAST2 = (TOP / 2) * 2;
   localparam int LAST3 = (TOP / 3) * 3;

   always_comb begin
      first = '0;
      last  = AW'(TOP);
      step  = 2'd1;
      bad   = 1'b0;
      case (mode)
         MODE_SUB: begin
            step = skip_three ? 2'd3 : 2'd2;
            last = skip_three ? AW'(LAST3) : AW'(LAST2);
         end
         MODE_REGION: begin
            first = lo;
            last  = hi;
            bad   = (lo > hi) || ({1'b0, hi} > (AW+1)'(TOP));
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pix_row_decoder.sv
module pix_row_decoder #(
   parameter int N  = 8,
   localparam int AW = $clog2(N)
) (
   input  logic          en,
   input  logic [AW-1:0] idx,
   output logic [N-1:0]  lines
);
   for (genvar g = 0; g < N; g++) begin : g_line
      assign lines[g] = en && (idx == AW'(g));
   end
endmodule

// File: rtl/pix_scan_seq.sv
module pix_scan_seq
   import pix_scan_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 8,
   parameter int IW   = 8,
   localparam int RAW = $clog2(ROWS),
   localparam int CAW = $clog2(COLS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [1:0]      mode,
   input  logic            skip_three,
   input  logic [RAW-1:0]  row_first,
   input  logic [RAW-1:0]  row_last,
   input  logic [CAW-1:0]  col_first,
   input  logic [CAW-1:0]  col_last,
   input  logic [IW-1:0]   int_cycles,
   output logic [ROWS-1:0] row_sel,
   output logic [CAW-1:0]  col_addr,
   output logic            pix_rst,
   output logic            xfer,
   output logic            pix_valid,
   output logic            frame_done,
   output logic            cfg_err
);
   if (ROWS < 2) begin : g_bad_rows
      $error("pix_scan_seq: ROWS must be at least 2");
   end
   if (COLS < 2) begin : g_bad_cols
      $error("pix_scan_seq: COLS must be at least 2");
   end
   if (IW < 1) begin : g_bad_iw
      $error("pix_scan_seq: IW must be at least 1");
   end

   scan_state_t    state;
   logic [RAW-1:0] row_idx, row_end;
   logic [CAW-1:0] col_idx, col_start, col_end;
   logic [1:0]     step_r;
   logic [IW-1:0]  int_r, cnt;
   logic           err_r;

   logic [RAW-1:0] r_first, r_last;
   logic [CAW-1:0] c_first, c_last;
   logic [1:0]     r_step, c_step;
   logic           r_bad, c_bad;

   pix_axis_plan #(.N(ROWS)) u_row_plan (
      .mode(mode), .skip_three(skip_three), .lo(row_first), .hi(row_last),
      .first(r_first), .last(r_last), .step(r_step), .bad(r_bad)
   );

   pix_axis_plan #(.N(COLS)) u_col_plan (
      .mode(mode), .skip_three(skip_three), .lo(col_first), .hi(col_last),
      .first(c_first), .last(c_last), .step(c_step), .bad(c_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         row_idx   <= '0;
         row_end   <= '0;
         col_idx   <= '0;
         col_start <= '0;
         col_end   <= '0;
         step_r    <= 2'd1;
         int_r     <= '0;
         cnt       <= '0;
         err_r     <= 1'b0;
      end else begin
         err_r <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  if (r_bad || c_bad) begin
                     err_r <= 1'b1;
                  end else begin
                     row_idx   <= r_first;
                     row_end   <= r_last;
                     col_idx   <= c_first;
                     col_start <= c_first;
                     col_end   <= c_last;
                     step_r    <= r_step;
                     int_r     <= int_cycles;
                     state     <= ST_RST;
                  end
               end
            end
            ST_RST: begin
               if (int_r == '0) begin
                  state <= ST_XFER;
               end else begin
                  cnt   <= int_r - 1'b1;
                  state <= ST_INTEG;
               end
            end
            ST_INTEG: begin
               if (cnt == '0) state <= ST_XFER;
               else           cnt   <= cnt - 1'b1;
            end
            ST_XFER: state <= ST_READ;
            ST_READ: begin
               if (col_idx == col_end) begin
                  col_idx <= col_start;
                  if (row_idx == row_end) begin
                     state <= ST_DONE;
                  end else begin
                     row_idx <= row_idx + RAW'(step_r);
                     state   <= ST_RST;
                  end
               end else begin
                  col_idx <= col_idx + CAW'(step_r);
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic row_active;
   assign row_active = (state != ST_IDLE) && (state != ST_DONE);

   pix_row_decoder #(.N(ROWS)) u_row_dec (
      .en(row_active), .idx(row_idx), .lines(row_sel)
   );

   assign col_addr   = col_idx;
   assign pix_rst    = (state == ST_RST);
   assign xfer       = (state == ST_XFER);
   assign pix_valid  = (state == ST_READ);
   assign frame_done = (state == ST_DONE);
   assign cfg_err    = err_r;

endmodule

// File: rtl/pix_scan_chk.sv
module pix_scan_chk #(
   parameter int ROWS = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [ROWS-1:0] row_sel,
   input logic            pix_rst,
   input logic            xfer,
   input logic            pix_valid,
   input logic            frame_done,
   input logic            cfg_err
);
   // R2
   row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_sel));

   // R2
   valid_has_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid || xfer || pix_rst) |-> ($countones(row_sel) == 1));

   // R3
   xfer_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> pix_valid);

   // R3
   rst_not_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_rst |=> (!pix_valid && !pix_rst));

   // R3
   row_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> $stable(row_sel));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (!frame_done && (row_sel == '0)));

   // R7
   err_no_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> ((row_sel == '0) && !pix_valid));
endmodule

bind pix_scan_seq pix_scan_chk #(.ROWS(ROWS)) u_scan_chk (
   .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .pix_rst(pix_rst),
   .xfer(xfer), .pix_valid(pix_valid), .frame_done(frame_done),
   .cfg_err(cfg_err)
);

// File: tb/pix_scan_seq_test.sv
module pix_scan_seq_test;
   localparam int ROWS = 6;
   localparam int COLS = 5;
   localparam int IW   = 4;
   localparam int RAW  = $clog2(ROWS);
   localparam int CAW  = $clog2(COLS);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [1:0]      mode = 2'b00;
   logic            skip_three = 1'b0;
   logic [RAW-1:0]  row_first = '0, row_last = '0;
   logic [CAW-1:0]  col_first = '0, col_last = '0;
   logic [IW-1:0]   int_cycles = '0;
   logic [ROWS-1:0] row_sel;
   logic [CAW-1:0]  col_addr;
   logic            pix_rst, xfer, pix_valid, frame_done, cfg_err;

   pix_scan_seq #(.ROWS(ROWS), .COLS(COLS), .IW(IW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .skip_three(skip_three), .row_first(row_first), .row_last(row_last),
      .col_first(col_first), .col_last(col_last), .int_cycles(int_cycles),
      .row_sel(row_sel), .col_addr(col_addr), .pix_rst(pix_rst), .xfer(xfer),
      .pix_valid(pix_valid), .frame_done(frame_done), .cfg_err(cfg_err)
   );

   always #5ns clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int log_r[0:63];
   int log_c[0:63];
   int nlog = 0;
   int n_rst = 0;
   int rst_cyc = 0;
   int last_valid_cyc = 0;
   int cur_int = 0;
   logic [ROWS-1:0] rst_row = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int row_of(input logic [ROWS-1:0] v);
      int r = -1;
      for (int i = 0; i < ROWS; i++) if (v[i]) r = i;
      return r;
   endfunction

   // Monitor: stamps strobes on falling edges and checks their distances
   always @(negedge clk) begin
      if (rst_n) begin
         if (pix_valid) begin
            if (nlog < 64) begin
               log_r[nlog] = row_of(row_sel);
               log_c[nlog] = int'(col_addr);
            end
            nlog++;
            last_valid_cyc = cyc;
         end
         if (pix_rst) begin
            n_rst++;
            rst_cyc = cyc;
            rst_row = row_sel;
         end
         if (xfer) begin
            // R3: xfer follows the reset strobe by int_cycles + 1, same row
            chk((cyc - rst_cyc == cur_int + 1) && (row_sel == rst_row),
                "R3 reset-to-transfer distance", cyc - rst_cyc, cur_int + 1);
         end
         if (frame_done) begin
            // R8: done is one cycle after the last data-valid
            chk(cyc == last_valid_cyc + 1, "R8 done timing",
                cyc - last_valid_cyc, 1);
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_frame(input logic [1:0] m, input bit sk3,
                            input int rf, input int rl, input int cf, input int cl,
                            input int iw, input bit disturb, input string req);
      int rs, re, cs, ce, st, k;
      bit got;
      @(negedge clk);
      nlog = 0;
      cur_int = iw;
      mode = m; skip_three = sk3;
      row_first = RAW'(rf); row_last = RAW'(rl);
      col_first = CAW'(cf); col_last = CAW'(cl);
      int_cycles = IW'(iw);
      pulse_start();
      if (disturb) begin
         repeat (3) @(negedge clk);
         // R9: new settings mid-frame; R10: a second start mid-frame
         mode = 2'b00; skip_three = 1'b1;
         row_first = '0; row_last = RAW'(ROWS - 1);
         col_first = '0; col_last = '0;
         int_cycles = IW'(iw + 2);
         pulse_start();
      end
      got = 1'b0;
      for (int i = 0; i < 5000 && !got; i++) begin
         @(negedge clk);
         if (frame_done) got = 1'b1;
      end
      chk(got, {req, " frame completes"}, int'(got), 1);
      // expected visiting order, built from the requirement
      case (m)
         2'b01: begin
            st = sk3 ? 3 : 2;
            rs = 0; re = ((ROWS - 1) / st) * st;
            cs = 0; ce = ((COLS - 1) / st) * st;
         end
         2'b10: begin st = 1; rs = rf; re = rl; cs = cf; ce = cl; end
         default: begin st = 1; rs = 0; re = ROWS - 1; cs = 0; ce = COLS - 1; end
      endcase
      k = 0;
      for (int r = rs; r <= re; r += st) begin
         for (int c = cs; c <= ce; c += st) begin
            if (k < 64) begin
               chk(log_r[k] == r, {req, " row order"}, log_r[k], r);
               chk(log_c[k] == c, {req, " column order"}, log_c[k], c);
            end
            k++;
         end
      end
      chk(nlog == k, {req, " pixel count"}, nlog, k);
      // R8: stays idle afterwards
      repeat (6) @(negedge clk);
      chk(nlog == k, "R8 no reads after done", nlog, k);
      chk(row_sel == '0, "R8 no row after done", int'(row_sel), 0);
      mode = 2'b00; skip_three = 1'b0;
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      chk({row_sel, pix_rst, xfer, pix_valid, frame_done, cfg_err} == '0,
          "R1 outputs in reset", int'(row_sel), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({row_sel, pix_rst, xfer, pix_valid, frame_done, cfg_err} == '0,
          "R1 outputs after reset", int'(pix_valid), 0);
   endtask

   task automatic test_bad_region(input int rf, input int rl, input int cf, input int cl);
      int rst_before;
      @(negedge clk);
      nlog = 0;
      rst_before = n_rst;
      mode = 2'b10;
      row_first = RAW'(rf); row_last = RAW'(rl);
      col_first = CAW'(cf); col_last = CAW'(cl);
      pulse_start();
      // R7: error in the cycle after the start strobe was sampled
      chk(cfg_err == 1'b1, "R7 error pulse", int'(cfg_err), 1);
      chk(row_sel == '0, "R7 no row on error", int'(row_sel), 0);
      @(negedge clk);
      chk(cfg_err == 1'b0, "R7 error lasts one cycle", int'(cfg_err), 0);
      repeat (10) @(negedge clk);
      chk(nlog == 0 && n_rst == rst_before, "R7 no scan on error", nlog, 0);
      mode = 2'b00;
   endtask

   initial begin
      #1500us;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      test_reset();
      run_frame(2'b00, 1'b0, 0, 0, 0, 0, 0, 1'b0, "R4 full scan");
      run_frame(2'b11, 1'b0, 0, 0, 0, 0, 1, 1'b0, "R4 mode 3 full scan");
      run_frame(2'b01, 1'b0, 0, 0, 0, 0, 2, 1'b0, "R5 step two");
      run_frame(2'b01, 1'b1, 0, 0, 0, 0, 1, 1'b0, "R5 step three");
      run_frame(2'b10, 1'b0, 1, 3, 2, 4, 3, 1'b0, "R6 region");
      run_frame(2'b10, 1'b0, 5, 5, 4, 4, 0, 1'b0, "R6 single pixel");
      run_frame(2'b10, 1'b0, 1, 2, 1, 3, 2, 1'b1, "R9 R10 mid-frame changes");
      test_bad_region(4, 2, 0, 1);
      test_bad_region(0, 1, 3, 1);
      test_bad_region(0, 1, 0, 5);
      test_bad_region(0, 6, 0, 1);
      run_frame(2'b00, 1'b0, 0, 0, 0, 0, 15, 1'b0, "R2 R4 long integration");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule